// File: doc/BRIEF.md
# Addressed Serial Control Port

This block is the slave side of a three-wire serial link with one extra return wire. It has an enable line, a serial clock, a data input, and an open-drain data output. The block works from a fast system clock. It synchronises the serial lines and finds their edges.

While the enable line is high, the block collects the first eight bits as an address. The address picks one of three operations: load control word 1, load control word 2, or read status. A load shifts in 32 data bits. The new word replaces the held word only when the enable line falls. A read returns a 27-bit status word on the data output. The status word holds seven input-pin bits and a 20-bit counter value.

When no read is in progress, the data output shows a status flag. The flag is chosen by fields in the two control words. The output can show the unlock flag, the end-of-count flag, the level of input pin 1 or pin 2, or a latched indication that pin 1 has changed.

Top module: `serial_ctrl_port`

## Requirements
- R1: The eight address bits are taken in transmit order, with the first bit as the MSB. Address 0x12 loads control word 1 and address 0x92 loads control word 2. Address 0x52 reads status and never changes either control word.
- R2: The 32 data bits that follow the address arrive LSB first, so the first data bit is bit 0. The held word keeps its old value while the enable line is high. It takes the new value only when the enable line falls.
- R3: Any other address makes the block ignore the rest of the transfer. Both control words stay unchanged.
- R4: If the enable line falls before 32 data bits have arrived, the write is discarded. Data bits after the 32nd are ignored.
- R5: A read sends 27 bits, MSB first: {I7..I1, C19..C0}. The first bit appears after the falling clock edge that follows the eighth address bit. Each later falling edge moves to the next bit. A 0 bit pulls the output low and a 1 bit releases it. Between the address and the first bit, and after the 27th bit, the output is released.
- R6: The input bits and the counter value are captured when the eighth address bit of a read arrives. I6 reads 0 when bit 12 of word 2 is 1. I7 reads 0 when bit 13 of word 2 is 1.
- R7: After reset, both control words are zero. This makes all ports inputs and clears oscillator select, dead-zone mode, timebase, deadlock clear and test bits.
- R8: Outside a read, the flag select is word 1 bits [21:20]. With select 00, the output is pulled low while the unlock flag is high. If word 2 bit 16 is 1, select 00 releases the output instead. Select 01 releases the output. Select 10 pulls the output low while count_done is high.
- R9: With select 11, the pin select is word 2 bits [15:14]. Value 00 releases the output. Value 01 makes the output follow pin I1: low when the pin is low. Value 10 does the same for pin I2. The output is released if the chosen pin is set as an output. Pin I1 is an output when word 2 bit 0 is 1, and pin I2 when word 2 bit 1 is 1.
- R10: With select 11 and pin select 11, a change on I1 pulls the output low and holds it low. The next rising edge of the enable line clears it. No change is latched when word 1 bits [19:16] equal 1110, which means the oscillator is stopped.
- R11: Clock and data activity while the enable line is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Serial enable; high during a transfer |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data in, sampled on the rising edge of ser_clk |
| ser_dout_low | output | 1 | Open-drain data out; 1 pulls the line low |
| in_pins | input | 7 | Levels of input pins I1 (bit 0) to I7 (bit 6) |
| cnt_value | input | 20 | Counter value to report |
| unlock_flag | input | 1 | PLL unlock indication |
| count_done | input | 1 | End-of-count indication |
| ctl1_word | output | 32 | Held control word 1 |
| ctl2_word | output | 32 | Held control word 2 |

## Verification
Each write is driven with a distinct, asymmetric pattern. This shows whether the bit order or the choice of word is wrong. The write is checked before and after the enable line falls, which confirms the commit point. Transfers with an unknown address, with 31 data bits and with 40 data bits show that bad writes are dropped and that the 32-bit window is kept. Reads are run with different pin and counter values, with the pins changed after the address, and with the counter-input bits set. These cases separate the capture moment, the bit order and the I6/I7 masking. Every flag selection is stepped through with its inputs toggled, so that a wrong selection shows as the wrong level.

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port #(
  parameter int CW = 32,
  parameter int AW = 8,
  parameter int CNTW = 20,
  parameter int NIN = 7,
  parameter logic [7:0] CODE_W1 = 8'h12,
  parameter logic [7:0] CODE_W2 = 8'h92,
  parameter logic [7:0] CODE_RD = 8'h52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_en,
  input  logic            ser_clk,
  input  logic            ser_din,
  output logic            ser_dout_low,
  input  logic [NIN-1:0]  in_pins,
  input  logic [CNTW-1:0] cnt_value,
  input  logic            unlock_flag,
  input  logic            count_done,
  output logic [CW-1:0]   ctl1_word,
  output logic [CW-1:0]   ctl2_word
);
  localparam int RW  = NIN + CNTW;
  localparam int WCW = $clog2(CW + 1);
  localparam int RIW = $clog2(RW + 1);
  localparam int ACW = $clog2(AW);
  localparam int F_REF = 16;
  localparam int F_DT  = 20;
  localparam int F_IL  = 14;
  localparam int F_ULD = 16;
  localparam int F_H6  = 12;
  localparam int F_L7  = 13;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_SKIP} st_t;

  logic [2:0] ce_p, sck_p, din_p;
  logic [NIN-1:0] pin_m, pin_s;
  logic i1_q;
  st_t state;
  logic [ACW-1:0] acnt;
  logic [AW-1:0] addr;
  logic wsel;
  logic [CW-1:0] wsh;
  logic [WCW-1:0] wcnt;
  logic [RW-1:0] rsh;
  logic [RIW-1:0] ridx;
  logic rd_bit, rd_valid;
  logic chg_flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_p <= '0; sck_p <= '0; din_p <= '0;
      pin_m <= '0; pin_s <= '0; i1_q <= 1'b0;
    end else begin
      ce_p <= {ce_p[1:0], ser_en};
      sck_p <= {sck_p[1:0], ser_clk};
      din_p <= {din_p[1:0], ser_din};
      pin_m <= in_pins;
      pin_s <= pin_m;
      i1_q <= pin_s[0];
    end

  wire ce_s     = ce_p[1];
  wire ce_rise  = ce_p[1] & ~ce_p[2];
  wire ce_fall  = ~ce_p[1] & ce_p[2];
  wire sck_rise = ce_s & sck_p[1] & ~sck_p[2];
  wire sck_fall = ce_s & ~sck_p[1] & sck_p[2];
  wire din_s    = din_p[1];
  wire [AW-1:0] addr_n = {addr[AW-2:0], din_s};

  wire [1:0] dt_sel  = ctl1_word[F_DT+1:F_DT];
  wire [3:0] ref_sel = ctl1_word[F_REF+3:F_REF];
  wire [1:0] il_sel  = ctl2_word[F_IL+1:F_IL];
  wire uld = ctl2_word[F_ULD];
  wire i6_v = ctl2_word[F_H6] ? 1'b0 : pin_s[NIN-2];
  wire i7_v = ctl2_word[F_L7] ? 1'b0 : pin_s[NIN-1];
  wire [RW-1:0] snap = {i7_v, i6_v, pin_s[NIN-3:0], cnt_value};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; acnt <= '0; addr <= '0; wsel <= 1'b0;
      wsh <= '0; wcnt <= '0; rsh <= '0; ridx <= '0;
      rd_bit <= 1'b0; rd_valid <= 1'b0;
      ctl1_word <= '0; ctl2_word <= '0;
    end else if (ce_rise) begin
      state <= S_ADDR; acnt <= '0; addr <= '0;
      wcnt <= '0; ridx <= '0; rd_valid <= 1'b0;
    end else if (ce_fall) begin
      if (state == S_WR && wcnt == WCW'(CW)) begin
        if (wsel) ctl2_word <= wsh;
        else ctl1_word <= wsh;
      end
      state <= S_IDLE; rd_valid <= 1'b0;
    end else if (sck_rise) begin
      case (state)
        S_ADDR: begin
          addr <= addr_n;
          if (acnt == ACW'(AW - 1)) begin
            if (addr_n == CODE_W1) begin state <= S_WR; wsel <= 1'b0; end
            else if (addr_n == CODE_W2) begin state <= S_WR; wsel <= 1'b1; end
            else if (addr_n == CODE_RD) begin state <= S_RD; rsh <= snap; end
            else state <= S_SKIP;
          end else acnt <= acnt + 1'b1;
        end
        S_WR: if (wcnt < WCW'(CW)) begin
          wsh <= {din_s, wsh[CW-1:1]};
          wcnt <= wcnt + 1'b1;
        end
        default: ;
      endcase
    end else if (sck_fall && state == S_RD) begin
      if (ridx < RIW'(RW)) begin
        rd_bit <= rsh[RW-1];
        rsh <= {rsh[RW-2:0], 1'b0};
        ridx <= ridx + 1'b1;
        rd_valid <= 1'b1;
      end else rd_valid <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chg_flag <= 1'b0;
    else if (ce_rise) chg_flag <= 1'b0;
    else if (pin_s[0] != i1_q && ref_sel != 4'b1110) chg_flag <= 1'b1;

  logic st_low;
  always_comb begin
    st_low = 1'b0;
    case (dt_sel)
      2'b00: st_low = ~uld & unlock_flag;
      2'b01: st_low = 1'b0;
      2'b10: st_low = count_done;
      2'b11:
        case (il_sel)
          2'b00: st_low = 1'b0;
          2'b01: st_low = ~ctl2_word[0] & ~pin_s[0];
          2'b10: st_low = ~ctl2_word[1] & ~pin_s[1];
          2'b11: st_low = ~ctl2_word[0] & chg_flag;
        endcase
    endcase
  end

  assign ser_dout_low = (state == S_RD) ? (rd_valid & ~rd_bit) : st_low;

  p_reset_words_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> (ctl1_word == '0 && ctl2_word == '0));
  p_commit_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ctl1_word) || !$stable(ctl2_word)) |-> $past(ce_fall));
  p_read_keeps_words_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD) |=> ($stable(ctl1_word) && $stable(ctl2_word)));
  p_idle_while_ce_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (state == S_IDLE));
  p_bit_holds_between_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && !sck_fall) |=> $stable(rd_bit));
  p_write_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WCW'(CW));
endmodule

// File: tb/test_serial_ctrl_port.sv
module test_serial_ctrl_port;
  localparam int H = 8;
  logic clk = 0, rst_n = 0;
  logic ser_en = 0, ser_clk = 0, ser_din = 0;
  logic ser_dout_low;
  logic [6:0] in_pins = '0;
  logic [19:0] cnt_value = '0;
  logic unlock_flag = 0, count_done = 0;
  logic [31:0] ctl1_word, ctl2_word;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  serial_ctrl_port i_serial_ctrl_port (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout_low(ser_dout_low), .in_pins(in_pins), .cnt_value(cnt_value),
    .unlock_flag(unlock_flag), .count_done(count_done),
    .ctl1_word(ctl1_word), .ctl2_word(ctl2_word));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ce_hi(); @(negedge clk); ser_clk = 0; ser_en = 1; wait_clk(H); endtask
  task automatic ce_lo(); @(negedge clk); ser_clk = 0; ser_en = 0; wait_clk(H); endtask
  task automatic send_bit(input logic b);
    @(negedge clk); ser_clk = 0; ser_din = b; wait_clk(H);
    ser_clk = 1; wait_clk(H);
  endtask
  task automatic send_addr(input logic [7:0] a);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
  endtask
  task automatic send_data(input logic [63:0] d, input int n);
    for (int i = 0; i < n; i++) send_bit(d[i]);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    ce_hi(); send_addr(a); send_data({32'h0, d}, 32); ce_lo();
  endtask

  function automatic logic [31:0] w2(input logic [4:0] dir, input logic h6, input logic l7,
                                     input logic [1:0] il, input logic uld);
    w2 = '0; w2[4:0] = dir; w2[12] = h6; w2[13] = l7; w2[15:14] = il; w2[16] = uld;
  endfunction
  function automatic logic [31:0] w1(input logic [3:0] rs, input logic [1:0] dt);
    w1 = 32'h0000_1234; w1[19:16] = rs; w1[21:20] = dt;
  endfunction

  task automatic t_reset();
    chk("R7 word1 reset", ctl1_word, 32'h0);
    chk("R7 word2 reset", ctl2_word, 32'h0);
    wait_clk(4); chk("R8 unlock low released", ser_dout_low, 0);
    unlock_flag = 1; wait_clk(4); chk("R8 unlock high pulls low", ser_dout_low, 1);
    unlock_flag = 0; wait_clk(4);
  endtask

  task automatic t_write();
    ce_hi(); send_addr(8'h12); send_data({32'h0, 32'hA5C3_1E7F}, 32);
    chk("R2 word1 held before fall", ctl1_word, 32'h0);
    ce_lo();
    chk("R1 R2 word1 loaded", ctl1_word, 32'hA5C3_1E7F);
    chk("R1 word2 untouched", ctl2_word, 32'h0);
    wr(8'h92, 32'h0180_0C00);
    chk("R1 word2 loaded", ctl2_word, 32'h0180_0C00);
    chk("R1 word1 kept", ctl1_word, 32'hA5C3_1E7F);
  endtask

  task automatic t_bad();
    wr(8'h13, 32'hFFFF_FFFF);
    chk("R3 bad addr word1", ctl1_word, 32'hA5C3_1E7F);
    chk("R3 bad addr word2", ctl2_word, 32'h0180_0C00);
    ce_hi(); send_addr(8'h12); send_data({32'h0, 32'h1111_1111}, 31); ce_lo();
    chk("R4 short write dropped", ctl1_word, 32'hA5C3_1E7F);
    ce_hi(); send_addr(8'h92); send_data({8'hFF, 32'h0F0F_3C3C}, 40); ce_lo();
    chk("R4 extra bits ignored", ctl2_word, 32'h0F0F_3C3C);
  endtask

  task automatic t_ignore();
    logic [31:0] a1, a2;
    a1 = ctl1_word; a2 = ctl2_word;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk); ser_din = i[1]; ser_clk = ~ser_clk; wait_clk(H);
    end
    ser_clk = 0; wait_clk(H);
    chk("R11 word1 unchanged", ctl1_word, a1);
    chk("R11 word2 unchanged", ctl2_word, a2);
    wr(8'h92, 32'h0000_0000);
    chk("R11 write after idle activity", ctl2_word, 32'h0);
  endtask

  task automatic rd(input string tag, input logic [26:0] exp, input logic [6:0] newpins);
    logic [31:0] a1, a2;
    a1 = ctl1_word; a2 = ctl2_word;
    ce_hi(); send_addr(8'h52);
    in_pins = newpins;
    wait_clk(4);
    chk({tag, " R5 released before first bit"}, ser_dout_low, 0);
    for (int k = 0; k < 27; k++) begin
      @(negedge clk); ser_clk = 0; wait_clk(H);
      if (ser_dout_low !== ~exp[26-k])
        chk($sformatf("%s R5 R6 bit %0d", tag, k), ser_dout_low, ~exp[26-k]);
      ser_clk = 1; wait_clk(H);
    end
    total++;
    @(negedge clk); ser_clk = 0; wait_clk(H);
    chk({tag, " R5 released after last bit"}, ser_dout_low, 0);
    ce_lo();
    chk({tag, " R1 read keeps word1"}, ctl1_word, a1);
    chk({tag, " R1 read keeps word2"}, ctl2_word, a2);
  endtask

  task automatic t_read();
    in_pins = 7'b1101001; cnt_value = 20'hB3C5A;
    rd("rdA", {7'b1101001, 20'hB3C5A}, 7'b0010110);
    in_pins = 7'b1111111; cnt_value = 20'h00F01;
    wr(8'h92, w2(5'd0, 1'b1, 1'b1, 2'b00, 1'b0));
    rd("rdB R6 masked", {7'b0011111, 20'h00F01}, 7'b0000000);
  endtask

  task automatic t_status();
    wr(8'h92, w2(5'd0, 0, 0, 2'b00, 1'b1));
    wr(8'h12, w1(4'h1, 2'b00));
    unlock_flag = 1; wait_clk(4);
    chk("R8 uld set releases", ser_dout_low, 0);
    wr(8'h12, w1(4'h1, 2'b01)); wait_clk(4);
    chk("R8 select 01 released", ser_dout_low, 0);
    unlock_flag = 0;
    wr(8'h12, w1(4'h1, 2'b10));
    count_done = 1; wait_clk(4); chk("R8 count done low", ser_dout_low, 1);
    count_done = 0; wait_clk(4); chk("R8 count idle released", ser_dout_low, 0);
    wr(8'h12, w1(4'h1, 2'b11));
    wr(8'h92, w2(5'd0, 0, 0, 2'b01, 0));
    in_pins = 7'b0000010; wait_clk(4); chk("R9 I1 low pulls low", ser_dout_low, 1);
    in_pins = 7'b0000001; wait_clk(4); chk("R9 I1 high released", ser_dout_low, 0);
    wr(8'h92, w2(5'd2, 0, 0, 2'b10, 0));
    in_pins = 7'b0; wait_clk(4); chk("R9 I2 as output released", ser_dout_low, 0);
    wr(8'h92, w2(5'd0, 0, 0, 2'b10, 0));
    wait_clk(4); chk("R9 I2 low pulls low", ser_dout_low, 1);
    wr(8'h92, w2(5'd0, 0, 0, 2'b00, 0));
    chk("R9 pin select 00 released", ser_dout_low, 0);
  endtask

  task automatic t_change();
    wr(8'h92, w2(5'd0, 0, 0, 2'b11, 0));
    wait_clk(4); chk("R10 no change released", ser_dout_low, 0);
    in_pins[0] = 1; wait_clk(6); chk("R10 change pulls low", ser_dout_low, 1);
    in_pins[0] = 0; wait_clk(6); chk("R10 latched low", ser_dout_low, 1);
    ce_hi(); chk("R10 cleared by enable rise", ser_dout_low, 0); ce_lo();
    wr(8'h12, w1(4'hE, 2'b11));
    in_pins[0] = 1; wait_clk(6);
    chk("R10 stopped oscillator no latch", ser_dout_low, 0);
    wr(8'h92, w2(5'd1, 0, 0, 2'b11, 0));
    wr(8'h12, w1(4'h1, 2'b11));
    in_pins[0] = 0; wait_clk(6);
    chk("R9 I1 output masks change", ser_dout_low, 0);
  endtask

  initial begin
    wait_clk(5); rst_n = 1; wait_clk(2);
    t_reset();
    t_write();
    t_bad();
    t_ignore();
    t_read();
    t_status();
    t_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule